// File: doc/BRIEF.md
# Fixed-Point Color Space Converter

This block converts a stream of three-component pixels from one color space to another for a display plane. Each pixel carries three 10-bit unsigned components and a valid strobe. The block multiplies the pixel by a programmable 3x3 matrix of signed fixed-point coefficients. It rounds the result to an integer, adds a signed integer offset, and saturates each component into a programmable window. Component 0 has its own offset and window. Components 1 and 2 share a second offset and window, which suits a luma channel plus two chroma channels.

Software programs the block through a plain write strobe with an address and a data word. Two complete matrices are held, and a control bit picks the one in use. A second control bit turns conversion on. When conversion is off, pixels leave the block unchanged after the same number of cycles. Register writes land in a staging copy. That copy becomes active only when no pixel is entering or in flight, so every pixel is processed with a single consistent set of values.

Top module: `csc_unit`

## Requirements
- R1: `out_valid` rises exactly three clock edges after `in_valid` was sampled high. Every accepted pixel produces exactly one output, in order, whatever gaps separate the input pixels.
- R2: While the enable bit (write address 0, data bit 0) is clear, `out_pix` equals the input pixel bit for bit, with the same three-cycle latency.
- R3: Component c occupies bits [10c+9:10c] of a pixel. Output component c is the sum over j of coefficient(c,j) times input component j. Each coefficient is 13-bit two's complement with 9 fractional bits. Coefficient(c,j) of matrix 0 is written at address 1+3c+j, and of matrix 1 at address 17+3c+j. The data sits in bits [12:0].
- R4: The full-precision matrix sum is rounded by adding 256 and then shifting right arithmetically by 9 bits, so exact halves round toward positive infinity.
- R5: A 10-bit two's complement offset is added after rounding. Address 10 holds the offset for component 0, and address 11 holds the offset shared by components 1 and 2.
- R6: Each result is saturated on its full signed value into [min, max], with no wraparound. The limits are 10-bit unsigned values: max0 at address 12, min0 at address 13, max12 at address 14, min12 at address 15.
- R7: When a programmed minimum exceeds its maximum, every affected component outputs that maximum.
- R8: Data bit 1 at address 0 selects matrix 1 when set and matrix 0 when clear.
- R9: Written values take effect only at a clock edge where `in_valid` is low and no earlier pixel is still in the pipeline. Pixels entering before that edge use the previous values, even if the write happened while they streamed.
- R10: After reset, `out_valid` and `out_pix` are zero and conversion is disabled. Both matrices are zero, both offsets are zero, both minimums are 0 and both maximums are 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register write address |
| cfg_wdata | input | KW (13) | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 3*CW (30) | Input pixel, component 0 in the low bits |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 3*CW (30) | Output pixel, component 0 in the low bits |

## Verification
The bench builds the block with its default parameters: 10-bit components and 13-bit coefficients with 9 fraction bits. At that size a single component spans only 1024 codes, so several phases sweep every code of each component under identity, half-gain and negative-gain matrices. This reaches every rounding tie and every saturation boundary. Extreme coefficients and offsets drive the signed sum far past both clamp limits. Inverted windows, matrix selection, bypass, writes made mid-stream and irregular valid gaps are each compared against an arithmetic model in the bench.

// File: rtl/csc_unit.sv
module csc_unit #(
  parameter int CW = 10,
  parameter int KW = 13,
  parameter int KF = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [4:0]      cfg_addr,
  input  logic [KW-1:0]   cfg_wdata,
  input  logic            in_valid,
  input  logic [3*CW-1:0] in_pix,
  output logic            out_valid,
  output logic [3*CW-1:0] out_pix
);
  localparam int NK = 9;
  localparam int PW = KW + CW + 1;
  localparam int SW = PW + 2;
  localparam int RW = SW - KF + 1;

  logic en_s, sel_s, en_a, sel_a;
  logic [2*NK-1:0][KW-1:0] k_s, k_a;
  logic [1:0][CW-1:0] off_s, off_a, max_s, max_a, min_s, min_a;
  logic busy;
  logic v1, e1, v2, e2, out_en;
  logic [3*CW-1:0] b1, b2, clamped;
  logic signed [PW-1:0] prod [NK];
  logic signed [PW-1:0] p1 [NK];
  logic signed [SW-1:0] acc [3];
  logic signed [RW-1:0] s2n [3];
  logic signed [RW-1:0] s2 [3];
  logic signed [RW-1:0] hi [3];
  logic signed [RW-1:0] lo [3];

  assign busy = in_valid | v1 | v2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s  <= 1'b0;
      sel_s <= 1'b0;
      k_s   <= '0;
      off_s <= '0;
      max_s <= {2{{CW{1'b1}}}};
      min_s <= '0;
    end else if (cfg_we) begin
      case (cfg_addr) inside
        5'd0: begin
          en_s  <= cfg_wdata[0];
          sel_s <= cfg_wdata[1];
        end
        [5'd1:5'd9]:   k_s[cfg_addr - 5'd1] <= cfg_wdata;
        [5'd17:5'd25]: k_s[cfg_addr - 5'd8] <= cfg_wdata;
        5'd10: off_s[0] <= cfg_wdata[CW-1:0];
        5'd11: off_s[1] <= cfg_wdata[CW-1:0];
        5'd12: max_s[0] <= cfg_wdata[CW-1:0];
        5'd13: min_s[0] <= cfg_wdata[CW-1:0];
        5'd14: max_s[1] <= cfg_wdata[CW-1:0];
        5'd15: min_s[1] <= cfg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a  <= 1'b0;
      sel_a <= 1'b0;
      k_a   <= '0;
      off_a <= '0;
      max_a <= {2{{CW{1'b1}}}};
      min_a <= '0;
    end else if (!busy) begin
      en_a  <= en_s;
      sel_a <= sel_s;
      k_a   <= k_s;
      off_a <= off_s;
      max_a <= max_s;
      min_a <= min_s;
    end
  end

  always_comb begin
    for (int i = 0; i < NK; i++)
      prod[i] = PW'($signed(k_a[(sel_a ? NK : 0) + i]))
              * PW'($signed({1'b0, in_pix[(i % 3)*CW +: CW]}));
  end

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      acc[c] = SW'(p1[3*c]) + SW'(p1[3*c+1]) + SW'(p1[3*c+2]) + SW'(1 <<< (KF-1));
      s2n[c] = RW'(acc[c] >>> KF) + RW'($signed(off_a[c == 0 ? 0 : 1]));
    end
  end

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      hi[c] = $signed(RW'(max_a[c == 0 ? 0 : 1]));
      lo[c] = (min_a[c == 0 ? 0 : 1] > max_a[c == 0 ? 0 : 1]) ? hi[c]
            : $signed(RW'(min_a[c == 0 ? 0 : 1]));
      if (s2[c] > hi[c])      clamped[c*CW +: CW] = hi[c][CW-1:0];
      else if (s2[c] < lo[c]) clamped[c*CW +: CW] = lo[c][CW-1:0];
      else                    clamped[c*CW +: CW] = s2[c][CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; e1 <= 1'b0; b1 <= '0;
      v2 <= 1'b0; e2 <= 1'b0; b2 <= '0;
      out_valid <= 1'b0; out_en <= 1'b0; out_pix <= '0;
      for (int i = 0; i < NK; i++) p1[i] <= '0;
      for (int c = 0; c < 3; c++) s2[c] <= '0;
    end else begin
      v1 <= in_valid; e1 <= en_a; b1 <= in_pix;
      for (int i = 0; i < NK; i++) p1[i] <= prod[i];
      v2 <= v1; e2 <= e1; b2 <= b1;
      for (int c = 0; c < 3; c++) s2[c] <= s2n[c];
      out_valid <= v2;
      out_en    <= e2;
      out_pix   <= e2 ? clamped : b2;
    end
  end

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid && !out_en) |-> (out_pix == $past(in_pix, 3)));

  assert_clamp_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_en) |-> (out_pix[CW-1:0] <= max_a[0] &&
      out_pix[2*CW-1:CW] <= max_a[1] && out_pix[3*CW-1:2*CW] <= max_a[1]));

  assert_clamp_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_en && min_a[0] <= max_a[0]) |-> (out_pix[CW-1:0] >= min_a[0]));

  assert_inverted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_en && min_a[1] > max_a[1]) |->
      (out_pix[2*CW-1:CW] == max_a[1] && out_pix[3*CW-1:2*CW] == max_a[1]));

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(k_a) && $stable(off_a) && $stable(max_a) &&
              $stable(min_a) && $stable(en_a) && $stable(sel_a)));
endmodule

// File: tb/sim_csc_unit.sv
module sim_csc_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [12:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic [29:0] in_pix = '0;
  logic out_valid;
  logic [29:0] out_pix;

  csc_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_pix(in_pix),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit h1 = 0, h2 = 0;
  bit ev [8];
  logic [29:0] ep [8];
  string et [8];
  string cur = "R10";
  int unsigned seed = 32'h1234_5678;

  int sk [18], ak [18];
  int soff [2], aoff [2], smax [2], amax [2], smin [2], amin [2];
  bit sen = 0, ssel = 0, aen = 0, asel = 0;

  task automatic check(bit ok, string req, logic [29:0] act, logic [29:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int sx(int v, int w);
    int m = v & ((1 << w) - 1);
    return (m >= (1 << (w-1))) ? m - (1 << w) : m;
  endfunction

  function automatic logic [29:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed[29:0];
  endfunction

  function automatic logic [29:0] model(logic [29:0] p);
    logic [29:0] r = '0;
    int x [3];
    if (!aen) return p;
    for (int j = 0; j < 3; j++) x[j] = int'(p[j*10 +: 10]);
    for (int c = 0; c < 3; c++) begin
      int g = (c == 0) ? 0 : 1;
      int s = 0;
      int lo;
      for (int j = 0; j < 3; j++) s += ak[(asel ? 9 : 0) + 3*c + j] * x[j];
      s = (s + 256) >>> 9;
      s = s + aoff[g];
      lo = (amin[g] > amax[g]) ? amax[g] : amin[g];
      if (s > amax[g]) s = amax[g];
      else if (s < lo) s = lo;
      r[c*10 +: 10] = s[9:0];
    end
    return r;
  endfunction

  function automatic void stage_write(int a, int d);
    if (a == 0) begin sen = d[0]; ssel = d[1]; end
    else if (a >= 1 && a <= 9) sk[a-1] = sx(d, 13);
    else if (a >= 17 && a <= 25) sk[a-8] = sx(d, 13);
    else if (a == 10) soff[0] = sx(d, 10);
    else if (a == 11) soff[1] = sx(d, 10);
    else if (a == 12) smax[0] = d & 1023;
    else if (a == 13) smin[0] = d & 1023;
    else if (a == 14) smax[1] = d & 1023;
    else if (a == 15) smin[1] = d & 1023;
  endfunction

  task automatic step(bit v, logic [29:0] p, bit we, int a, int d);
    int s;
    @(negedge clk);
    cyc++;
    s = cyc % 8;
    check(out_valid === ev[s], "R1", {29'd0, out_valid}, {29'd0, ev[s]});
    if (ev[s] && out_valid) check(out_pix === ep[s], et[s], out_pix, ep[s]);
    ev[s] = 0;
    in_valid = v; in_pix = p;
    cfg_we = we; cfg_addr = a[4:0]; cfg_wdata = d[12:0];
    if (v) begin
      ev[(cyc+3) % 8] = 1;
      ep[(cyc+3) % 8] = model(p);
      et[(cyc+3) % 8] = cur;
    end
    if (!v && !h1 && !h2) begin
      aen = sen; asel = ssel; ak = sk; aoff = soff; amax = smax; amin = smin;
    end
    h2 = h1; h1 = v;
    if (we) stage_write(a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0);
  endtask

  task automatic wr(int a, int d);
    step(0, '0, 1, a, d);
  endtask

  task automatic mat(int s, int a0, int a1, int a2, int a3, int a4,
                     int a5, int a6, int a7, int a8);
    int k [9] = '{a0, a1, a2, a3, a4, a5, a6, a7, a8};
    for (int i = 0; i < 9; i++) wr((s ? 17 : 1) + i, k[i]);
  endtask

  task automatic lim(int o0, int o12, int mn0, int mx0, int mn12, int mx12);
    wr(10, o0); wr(11, o12); wr(12, mx0); wr(13, mn0); wr(14, mx12); wr(15, mn12);
  endtask

  task automatic ctl(int en, int sel);
    wr(0, en | (sel << 1));
    idle(3);
  endtask

  initial begin
    for (int i = 0; i < 18; i++) begin sk[i] = 0; ak[i] = 0; end
    for (int g = 0; g < 2; g++) begin
      soff[g] = 0; aoff[g] = 0; smax[g] = 1023; amax[g] = 1023; smin[g] = 0; amin[g] = 0;
    end
    for (int i = 0; i < 8; i++) begin ev[i] = 0; ep[i] = '0; et[i] = "R1"; end
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10", {29'd0, out_valid}, 30'd0);
    check(out_pix === 30'd0, "R10", out_pix, 30'd0);
    rst_n = 1'b1;

    // R10: disabled after reset, pixels pass through
    cur = "R10";
    for (int i = 0; i < 40; i++) step(1, rnd(), 0, 0, 0);
    idle(3);

    // R3: identity matrix, full sweep of every component code
    cur = "R3";
    mat(0, 512, 0, 0, 0, 512, 0, 0, 0, 512);
    lim(0, 0, 0, 1023, 0, 1023);
    ctl(1, 0);
    for (int v = 0; v < 1024; v++)
      step(1, {10'((v*7) % 1024), 10'(1023 - v), 10'(v)}, 0, 0, 0);
    idle(3);

    // R5: mixed-sign matrix with offsets of both signs
    cur = "R5";
    mat(0, 131, 257, 50, -76, -148, 224, 224, -188, -36);
    lim(64, -100, 0, 1023, 0, 1023);
    ctl(1, 0);
    for (int i = 0; i < 1500; i++) step(1, rnd(), 0, 0, 0);
    lim(-64, 300, 0, 1023, 0, 1023);
    idle(3);
    for (int i = 0; i < 800; i++) step(1, rnd(), 0, 0, 0);
    idle(3);

    // R4: half gains and a tiny gain, every code sweeps the rounding ties
    cur = "R4";
    mat(0, 256, 0, 0, 0, -256, 0, 0, 0, 1);
    lim(0, 200, 0, 1023, 0, 1023);
    idle(3);
    for (int v = 0; v < 1024; v++) step(1, {10'(v), 10'(v), 10'(v)}, 0, 0, 0);
    mat(0, 0, 0, 0, 0, 768, -256, 0, 0, 0);
    lim(0, -300, 0, 1023, 0, 1023);
    idle(3);
    for (int v = 0; v < 1024; v++) step(1, {10'(1023 - v), 10'(v), 10'(v)}, 0, 0, 0);
    idle(3);

    // R6: extreme coefficients, narrow windows
    cur = "R6";
    mat(0, 4095, -4096, 0, -4096, 4095, 4095, 1000, -4096, 300);
    lim(-512, 511, 16, 235, 16, 240);
    idle(3);
    for (int i = 0; i < 1500; i++) step(1, rnd(), 0, 0, 0);
    idle(3);

    // R7: minimum above maximum
    cur = "R7";
    mat(0, 512, 0, 0, 0, 512, 0, 0, 0, 512);
    lim(0, 0, 900, 100, 1000, 3);
    idle(3);
    for (int i = 0; i < 400; i++) step(1, rnd(), 0, 0, 0);
    idle(3);

    // R8: matrix selection
    cur = "R8";
    lim(0, 0, 0, 1023, 0, 1023);
    mat(1, 0, 0, 512, 0, 512, 0, 512, 0, 0);
    idle(3);
    for (int i = 0; i < 300; i++) step(1, rnd(), 0, 0, 0);
    ctl(1, 1);
    for (int i = 0; i < 300; i++) step(1, rnd(), 0, 0, 0);
    ctl(1, 0);
    for (int i = 0; i < 100; i++) step(1, rnd(), 0, 0, 0);
    idle(3);

    // R9: write during a continuous stream waits for an idle gap
    cur = "R9";
    for (int i = 0; i < 100; i++) step(1, rnd(), 0, 0, 0);
    step(1, rnd(), 1, 1, 1024);
    step(1, rnd(), 1, 11, 77);
    for (int i = 0; i < 100; i++) step(1, rnd(), 0, 0, 0);
    step(0, '0, 0, 0, 0);
    step(1, rnd(), 0, 0, 0);
    idle(3);
    for (int i = 0; i < 100; i++) step(1, rnd(), 0, 0, 0);
    idle(3);

    // R1: irregular valid pattern
    cur = "R1";
    for (int i = 0; i < 1500; i++) begin
      logic [29:0] r = rnd();
      step(r[3] | r[11], rnd(), 0, 0, 0);
    end
    idle(3);

    // R2: disabled with a nonzero matrix, exhaustive codes
    cur = "R2";
    mat(0, -4096, 77, 4095, 3, -9, 100, 4000, -1, 5);
    ctl(0, 0);
    for (int v = 0; v < 1024; v++) step(1, {10'(v), 10'(v ^ 10'h2AA), 10'(1023 - v)}, 0, 0, 0);
    ctl(0, 1);
    for (int i = 0; i < 200; i++) step(1, rnd(), 0, 0, 0);
    idle(5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule